// File: doc/BRIEF.md
# Inertial Motion Interrupt Generator

This block watches a stream of signed three-axis acceleration samples. Each sample comes with a one-cycle data-ready strobe. The block raises an interrupt line when the axis events it has been configured to watch satisfy one of four combination rules:

- any enabled event (OR);
- all enabled events (AND);
- a change of orientation into a known direction (movement);
- remaining in a known direction (position).

Each axis can flag a high event, when it is beyond the positive threshold, and a low event, when it is at or below the negative threshold. Each of these six events has its own enable bit. Before the comparison, every sample is divided down by a power of two, so that one threshold step is a fixed fraction of full scale.

A minimum duration, counted in samples, filters short disturbances. An optional latch holds the interrupt and its captured source flags until the host reads them. With the latch off, the interrupt follows the condition sample by sample.

A host reads the source word at any time and pulses the read strobe to acknowledge. The four rules let the same hardware serve three uses:

- wake-up on motion;
- free-fall style AND detection;
- tilt or orientation reporting.

Top module: `motion_irq_gen`

## Requirements
- R1: The rule is chosen by {cfg_all, cfg_dir}: 00 OR, 01 movement, 10 AND, 11 position. The interrupt and source word are registered. They change only on the clock edge that takes a sample strobe, or on the edge that takes a read strobe. Otherwise they hold.
- R2: Each sample is arithmetically shifted right by SCALE_SHIFT, which rounds toward minus infinity. An axis high event is a scaled value strictly greater than the threshold. An axis low event is a scaled value less than or equal to the negated threshold.
- R3: In OR mode the condition holds when at least one enabled event is active. Disabled events never contribute.
- R4: In AND mode the condition holds when every enabled event is active. With no event enabled the condition never holds.
- R5: A known orientation requires exactly one axis to have a high or low event, and that event must be enabled. Any other case is unknown.
- R6: In movement mode the condition holds on a sample whose orientation is known and differs from the orientation of the previous sample. The previous orientation is unknown after reset. The interrupt then lasts one sample, and the minimum duration does not apply.
- R7: In position mode the condition holds on every sample whose orientation is known, subject to the minimum duration.
- R8: Bit 7 of the threshold input and bit 7 of the duration input have no effect.
- R9: With duration N, the interrupt asserts on the (N+1)-th consecutive qualifying sample. A non-qualifying sample restarts the count, and N = 0 asserts on the first qualifying sample.
- R10: With the latch on, the interrupt and flags stay set until a read strobe, which clears them on the next edge. A qualifying sample taken on the same edge as the read wins and recaptures the flags.
- R11: With the latch off, the interrupt clears on the first non-qualifying sample, and a read strobe has no effect.
- R12: The source word is {0, active, ZH, ZL, YH, YL, XH, XL}, from bit 7 down to bit 0. The event flags are the enabled events of the sample on which the interrupt asserted. The word is all zero whenever the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new sample |
| acc_x | input | SAMPLE_W | Signed X acceleration |
| acc_y | input | SAMPLE_W | Signed Y acceleration |
| acc_z | input | SAMPLE_W | Signed Z acceleration |
| cfg_evt_en | input | 6 | Event enables, ZH ZL YH YL XH XL from bit 5 down |
| cfg_all | input | 1 | Rule select, upper bit |
| cfg_dir | input | 1 | Rule select, lower bit (orientation rules) |
| cfg_thresh | input | THR_W+1 | Threshold, top bit ignored |
| cfg_dur | input | DUR_W+1 | Minimum duration in samples, top bit ignored |
| cfg_latch | input | 1 | Hold interrupt until read |
| src_rd | input | 1 | Host read strobe for the source word |
| irq | output | 1 | Interrupt line |
| src_word | output | 8 | Source status word |

## Verification
Every result is due one clock after the edge that takes the sample or read strobe. The comparison path, the orientation decode and the duration test are combinational ahead of the single output register. The bench drives a strobe on a falling edge and samples the outputs on the next falling edge, which lies half a period after the only register on the path.

Rows of the vector table run back to back without a reset. Each expected source word therefore follows from the interrupt state left by the row before. The movement rows also depend on the orientation of the previous row, which the table order fixes. Idle cycles inserted between strobes confirm that the outputs do not move without a strobe.

// File: rtl/motion_irq_pkg.sv
package motion_irq_pkg;

   localparam int EVT_N  = 6;
   localparam int AXIS_N = 3;

   // rule select, decoded from {cfg_all, cfg_dir}
   typedef enum logic [1:0] {
      MODE_OR   = 2'b00,
      MODE_MOVE = 2'b01,
      MODE_AND  = 2'b10,
      MODE_POS  = 2'b11
   } mode_e;

   // orientation code: 2*axis + (1 for high side)
   typedef enum logic [2:0] {
      ORI_XL  = 3'd0,
      ORI_XH  = 3'd1,
      ORI_YL  = 3'd2,
      ORI_YH  = 3'd3,
      ORI_ZL  = 3'd4,
      ORI_ZH  = 3'd5,
      ORI_UNK = 3'd7
   } orient_e;

endpackage

// File: rtl/motion_axis_cmp.sv
module motion_axis_cmp #(
   parameter int SAMPLE_W    = 12,
   parameter int SCALE_SHIFT = 4,
   parameter int THR_W       = 7
) (
   input  logic signed [SAMPLE_W-1:0] smp,
   input  logic        [THR_W-1:0]    thr,
   output logic                       evt_hi,
   output logic                       evt_lo
);
   localparam int SW = SAMPLE_W - SCALE_SHIFT;
   localparam int CW = ((SW > THR_W + 1) ? SW : THR_W + 1) + 1;

   if (SW < 2) begin : g_bad_shift
      $error("motion_axis_cmp: SCALE_SHIFT leaves fewer than 2 sample bits");
   end

   logic [SW-1:0]        scaled;
   logic signed [CW-1:0] scl_ext;
   logic signed [CW-1:0] thr_pos;
   logic signed [CW-1:0] thr_neg;

   // slicing off low bits of a two's-complement value is a floor division
   if (SCALE_SHIFT == 0) begin : g_noscale
      assign scaled = smp;
   end else begin : g_scale
      assign scaled = smp[SAMPLE_W-1:SCALE_SHIFT];
   end

   assign scl_ext = signed'({{(CW-SW){scaled[SW-1]}}, scaled});
   assign thr_pos = signed'({{(CW-THR_W){1'b0}}, thr});
   assign thr_neg = -thr_pos;

   assign evt_hi = scl_ext > thr_pos;
   assign evt_lo = scl_ext <= thr_neg;

   always_comb begin
      AST_HI_LO_EXCL: assert (!(evt_hi && evt_lo)); // R2
   end

endmodule

// File: rtl/motion_orient.sv
module motion_orient
   import motion_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [EVT_N-1:0] evt,
   input  logic [EVT_N-1:0] evt_en,
   output orient_e          cur,
   output logic             known,
   output logic             moved
);
   logic [AXIS_N-1:0] axis_out;
   logic              single;
   orient_e           prev_q;

   always_comb begin
      for (int i = 0; i < AXIS_N; i++) begin
         axis_out[i] = evt[2*i] | evt[2*i+1];
      end
   end

   assign single = $onehot(axis_out);

   always_comb begin
      cur = ORI_UNK;
      for (int i = 0; i < AXIS_N; i++) begin
         if (single && axis_out[i]) begin
            if (evt[2*i+1] && evt_en[2*i+1]) begin
               cur = orient_e'(3'(2*i+1));
            end else if (evt[2*i] && evt_en[2*i]) begin
               cur = orient_e'(3'(2*i));
            end
         end
      end
   end

   assign known = (cur != ORI_UNK);
   assign moved = known && (cur != prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= ORI_UNK;
      end else if (smp_vld) begin
         prev_q <= cur;
      end
   end

   AST_KNOWN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      known |-> ($countones(evt & evt_en) == 1)); // R5

   AST_UNK_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (prev_q == ORI_UNK)); // R6

endmodule

// File: rtl/motion_dur_cnt.sv
module motion_dur_cnt #(
   parameter int DUR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic             cond,
   input  logic             bypass,
   input  logic [DUR_W-1:0] dur,
   output logic             fire
);
   logic [DUR_W-1:0] cnt_q;

   assign fire = cond && (bypass || (cnt_q >= dur));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (smp_vld) begin
         if (!cond) begin
            cnt_q <= '0;
         end else if (cnt_q < dur) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_DUR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !cond) |=> (cnt_q == '0)); // R9

   AST_DUR_NOMOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/motion_irq_gen.sv
module motion_irq_gen
   import motion_irq_pkg::*;
#(
   parameter int SAMPLE_W    = 12,
   parameter int SCALE_SHIFT = 4,
   parameter int THR_W       = 7,
   parameter int DUR_W       = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_valid,
   input  logic signed [SAMPLE_W-1:0] acc_x,
   input  logic signed [SAMPLE_W-1:0] acc_y,
   input  logic signed [SAMPLE_W-1:0] acc_z,
   input  logic [EVT_N-1:0]           cfg_evt_en,
   input  logic                       cfg_all,
   input  logic                       cfg_dir,
   input  logic [THR_W:0]             cfg_thresh,
   input  logic [DUR_W:0]             cfg_dur,
   input  logic                       cfg_latch,
   input  logic                       src_rd,
   output logic                       irq,
   output logic [7:0]                 src_word
);
   if (THR_W < 1 || DUR_W < 1) begin : g_bad_width
      $error("motion_irq_gen: THR_W and DUR_W must be at least 1");
   end
   if (SAMPLE_W <= SCALE_SHIFT) begin : g_bad_scale
      $error("motion_irq_gen: SCALE_SHIFT must be below SAMPLE_W");
   end

   mode_e                     mode;
   logic signed [SAMPLE_W-1:0] axis_smp [AXIS_N];
   logic [EVT_N-1:0]          evt;
   logic [EVT_N-1:0]          evt_on;
   logic                      cond;
   logic                      fire;
   orient_e                   ori_cur;
   logic                      ori_known;
   logic                      ori_moved;
   logic                      irq_q;
   logic [EVT_N-1:0]          flag_q;

   assign mode = mode_e'({cfg_all, cfg_dir});

   assign axis_smp[0] = acc_x;
   assign axis_smp[1] = acc_y;
   assign axis_smp[2] = acc_z;

   for (genvar a = 0; a < AXIS_N; a++) begin : g_axis
      motion_axis_cmp #(
         .SAMPLE_W   (SAMPLE_W),
         .SCALE_SHIFT(SCALE_SHIFT),
         .THR_W      (THR_W)
      ) u_cmp (
         .smp   (axis_smp[a]),
         .thr   (cfg_thresh[THR_W-1:0]),
         .evt_hi(evt[2*a+1]),
         .evt_lo(evt[2*a])
      );
   end

   assign evt_on = evt & cfg_evt_en;

   motion_orient u_orient (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_vld(sample_valid),
      .evt    (evt),
      .evt_en (cfg_evt_en),
      .cur    (ori_cur),
      .known  (ori_known),
      .moved  (ori_moved)
   );

   always_comb begin
      unique case (mode)
         MODE_OR:   cond = |evt_on;
         MODE_AND:  cond = (|cfg_evt_en) && ((evt | ~cfg_evt_en) == '1);
         MODE_MOVE: cond = ori_moved;
         MODE_POS:  cond = ori_known;
         default:   cond = 1'b0;
      endcase
   end

   motion_dur_cnt #(.DUR_W(DUR_W)) u_dur (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_vld(sample_valid),
      .cond   (cond),
      .bypass (mode == MODE_MOVE),
      .dur    (cfg_dur[DUR_W-1:0]),
      .fire   (fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         flag_q <= '0;
      end else if (sample_valid && fire) begin
         irq_q <= 1'b1;
         if (!irq_q || (cfg_latch && src_rd)) begin
            flag_q <= evt_on;
         end
      end else if (sample_valid && !cfg_latch) begin
         irq_q  <= 1'b0;
         flag_q <= '0;
      end else if (src_rd && cfg_latch) begin
         irq_q  <= 1'b0;
         flag_q <= '0;
      end
   end

   assign irq      = irq_q;
   assign src_word = {1'b0, irq_q, flag_q};

   AST_IDLE_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_q |-> (flag_q == '0)); // R12

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_valid && !src_rd) |=> ($stable(irq_q) && $stable(flag_q))); // R1

   AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_latch && irq_q && !src_rd) |=> irq_q); // R10

   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_latch && src_rd && !sample_valid) |=> !irq_q); // R10

   AST_UNLATCHED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_latch && sample_valid && !fire) |=> !irq_q); // R11

   AST_MOVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_MOVE && !cfg_latch && sample_valid && !ori_moved) |=> !irq_q); // R6

   AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && fire) |=> irq_q); // R9

endmodule

// File: tb/motion_irq_gen_bench.sv
module motion_irq_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NROW = 21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_valid = 1'b0;
   logic signed [11:0] acc_x = '0, acc_y = '0, acc_z = '0;
   logic [5:0]  cfg_evt_en = 6'h3F;
   logic        cfg_all = 1'b0, cfg_dir = 1'b0;
   logic [7:0]  cfg_thresh = 8'd10;
   logic [7:0]  cfg_dur = 8'd0;
   logic        cfg_latch = 1'b0;
   logic        src_rd = 1'b0;
   logic        irq;
   logic [7:0]  src_word;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   motion_irq_gen u_motion_irq_gen (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
      .cfg_evt_en(cfg_evt_en), .cfg_all(cfg_all), .cfg_dir(cfg_dir),
      .cfg_thresh(cfg_thresh), .cfg_dur(cfg_dur), .cfg_latch(cfg_latch),
      .src_rd(src_rd), .irq(irq), .src_word(src_word)
   );

   function automatic logic [11:0] s16(int n);
      return 12'(n * 16);
   endfunction

   // {all, dir, en[5:0], thr[7:0], x, y, z, exp_irq, exp_src[7:0]}
   localparam logic [60:0] TBL [NROW] = '{
      {1'b0,1'b0,6'h3F,8'd10,  s16(0),  s16(0),  s16(0),  1'b0,8'h00},
      {1'b0,1'b0,6'h3F,8'd10,  s16(11), s16(0),  s16(0),  1'b1,8'h42},
      {1'b0,1'b0,6'h3F,8'd10,  s16(10), s16(0),  s16(0),  1'b0,8'h00},
      {1'b0,1'b0,6'h3F,8'd10,  s16(-10),s16(0),  s16(0),  1'b1,8'h41},
      {1'b0,1'b0,6'h3F,8'd10,  s16(-9), s16(0),  s16(0),  1'b0,8'h00},
      {1'b0,1'b0,6'h02,8'd10,  s16(0),  s16(-20),s16(0),  1'b0,8'h00},
      {1'b1,1'b0,6'h22,8'd10,  s16(20), s16(0),  s16(20), 1'b1,8'h62},
      {1'b1,1'b0,6'h22,8'd10,  s16(20), s16(0),  s16(5),  1'b0,8'h00},
      {1'b1,1'b0,6'h00,8'd10,  s16(20), s16(20), s16(20), 1'b0,8'h00},
      {1'b0,1'b0,6'h3F,8'h8A,  s16(11), s16(0),  s16(0),  1'b1,8'h42},
      {1'b0,1'b0,6'h3F,8'h8A,  s16(10), s16(0),  s16(0),  1'b0,8'h00},
      {1'b0,1'b1,6'h3F,8'd10,  s16(0),  s16(0),  s16(20), 1'b1,8'h60},
      {1'b0,1'b1,6'h3F,8'd10,  s16(0),  s16(0),  s16(25), 1'b0,8'h00},
      {1'b0,1'b1,6'h3F,8'd10,  s16(0),  s16(-15),s16(0),  1'b1,8'h44},
      {1'b0,1'b1,6'h3F,8'd10,  s16(20), s16(-15),s16(0),  1'b0,8'h00},
      {1'b0,1'b1,6'h3F,8'd10,  s16(0),  s16(-15),s16(0),  1'b1,8'h44},
      {1'b1,1'b1,6'h3F,8'd10,  s16(0),  s16(-15),s16(0),  1'b1,8'h44},
      {1'b1,1'b1,6'h3F,8'd10,  s16(0),  s16(-15),s16(0),  1'b1,8'h44},
      {1'b1,1'b1,6'h3F,8'd10,  s16(0),  s16(0),  s16(0),  1'b0,8'h00},
      {1'b1,1'b1,6'h3B,8'd10,  s16(0),  s16(-15),s16(0),  1'b0,8'h00},
      {1'b1,1'b1,6'h3F,8'd10,  s16(-30),s16(0),  s16(0),  1'b1,8'h41}
   };

   function automatic string row_tag(int i);
      if (i < 6)  return "R3/R2";
      if (i < 9)  return "R4";
      if (i < 11) return "R8";
      if (i < 16) return "R6/R5";
      return "R7/R5";
   endfunction

   task automatic check(string tag, logic exp_irq, logic [7:0] exp_src);
      n_chk++;
      if (irq !== exp_irq || src_word !== exp_src) begin
         n_bad++;
         $display("FAIL %s: irq=%b src=%02h expected irq=%b src=%02h",
                  tag, irq, src_word, exp_irq, exp_src);
      end
   endtask

   task automatic cfg(logic all, logic dir, logic [5:0] en, logic [7:0] thr,
                      logic [7:0] dur, logic lat);
      cfg_all = all; cfg_dir = dir; cfg_evt_en = en;
      cfg_thresh = thr; cfg_dur = dur; cfg_latch = lat;
   endtask

   task automatic raw(logic [11:0] x, logic [11:0] y, logic [11:0] z, logic rd);
      acc_x = x; acc_y = y; acc_z = z;
      sample_valid = 1'b1; src_rd = rd;
      @(negedge clk);
      sample_valid = 1'b0; src_rd = 1'b0;
   endtask

   task automatic smp(int x, int y, int z);
      raw(s16(x), s16(y), s16(z), 1'b0);
   endtask

   task automatic rd_only();
      src_rd = 1'b1;
      @(negedge clk);
      src_rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      repeat (2) @(negedge clk);
      check("R1 reset state", 1'b0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, latch off, duration 0
      for (int i = 0; i < NROW; i++) begin
         logic [60:0] r;
         r = TBL[i];
         cfg(r[60], r[59], r[58:53], r[52:45], 8'd0, 1'b0);
         raw(r[44:33], r[32:21], r[20:9], 1'b0);
         check($sformatf("%s row %0d", row_tag(i), i), r[8], r[7:0]);
      end

      // R2 scaling rounds toward minus infinity
      do_reset();
      cfg(1'b0, 1'b0, 6'h3F, 8'd10, 8'd0, 1'b0);
      raw(12'(-159), 12'd0, 12'd0, 1'b0);
      check("R2 floor -159", 1'b1, 8'h41);
      raw(12'd175, 12'd0, 12'd0, 1'b0);
      check("R2 scaled 10 not high", 1'b0, 8'h00);
      raw(12'd176, 12'd0, 12'd0, 1'b0);
      check("R2 scaled 11 high", 1'b1, 8'h42);

      // R9 duration count and restart
      do_reset();
      cfg(1'b0, 1'b0, 6'h3F, 8'd10, 8'd3, 1'b0);
      for (int k = 0; k < 3; k++) begin
         smp(20, 0, 0);
         check($sformatf("R9 dur3 sample %0d", k), 1'b0, 8'h00);
      end
      smp(20, 0, 0);
      check("R9 dur3 fourth sample", 1'b1, 8'h42);
      smp(0, 0, 0);
      check("R11 drop on quiet", 1'b0, 8'h00);
      smp(20, 0, 0); smp(20, 0, 0); smp(0, 0, 0);
      for (int k = 0; k < 3; k++) smp(20, 0, 0);
      check("R9 count restarted", 1'b0, 8'h00);
      smp(20, 0, 0);
      check("R9 fires after restart", 1'b1, 8'h42);

      // R8 duration top bit ignored
      smp(0, 0, 0);
      cfg(1'b0, 1'b0, 6'h3F, 8'd10, 8'h80, 1'b0);
      smp(20, 0, 0);
      check("R8 duration bit7 ignored", 1'b1, 8'h42);

      // R6 movement bypasses duration
      do_reset();
      cfg(1'b0, 1'b1, 6'h3F, 8'd10, 8'd3, 1'b0);
      smp(0, 0, 20);
      check("R6 move ignores duration", 1'b1, 8'h60);
      smp(0, 0, 20);
      check("R6 move one sample", 1'b0, 8'h00);

      // R7 position honours duration
      do_reset();
      cfg(1'b1, 1'b1, 6'h3F, 8'd10, 8'd2, 1'b0);
      smp(0, 0, 20);
      check("R7 pos dur2 s1", 1'b0, 8'h00);
      smp(0, 0, 20);
      check("R7 pos dur2 s2", 1'b0, 8'h00);
      smp(0, 0, 20);
      check("R7 pos dur2 s3", 1'b1, 8'h60);

      // R10 latch
      do_reset();
      cfg(1'b0, 1'b0, 6'h3F, 8'd10, 8'd0, 1'b1);
      smp(20, 0, 0);
      check("R10 latch set", 1'b1, 8'h42);
      smp(0, 0, 0);
      check("R10 latch holds on quiet", 1'b1, 8'h42);
      repeat (3) @(negedge clk);
      check("R1 no strobe no change", 1'b1, 8'h42);
      rd_only();
      check("R10 read clears", 1'b0, 8'h00);
      smp(0, 0, 0);
      check("R12 zero when idle", 1'b0, 8'h00);
      smp(20, 0, 0);
      raw(s16(-20), 12'd0, 12'd0, 1'b1);
      check("R10 fire wins over read", 1'b1, 8'h41);
      rd_only();
      check("R10 second read clears", 1'b0, 8'h00);

      // R11 read has no effect when unlatched
      do_reset();
      cfg(1'b0, 1'b0, 6'h3F, 8'd10, 8'd0, 1'b0);
      smp(20, 0, 0);
      rd_only();
      check("R11 read ignored", 1'b1, 8'h42);
      smp(0, 0, 0);
      check("R11 clears on quiet", 1'b0, 8'h00);

      finish_run();
   end

endmodule